// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block listens to the clock and data lines of a two-wire serial bus. It is clocked by a system clock that runs far faster than the bus clock, and it never drives either line. Both lines pass through two-flop synchronizers. The monitor then compares each new sample with the previous one to find the framing conditions. A falling data line while the bus clock is high opens a transfer. A rising data line while the bus clock is high closes it.

The monitor reports each condition as a one-cycle pulse. An opening condition seen while a transfer is already in progress is reported as a repeated start, and the bus stays owned. A busy level rises with the opening condition. After the closing condition it stays high for a programmable number of system clocks. The monitor counts the bits of each nine-bit frame (eight data bits and one acknowledge bit). A close that lands inside a frame raises an abort pulse together with the stop pulse. A data level that does not hold across the high phase of a bus-clock pulse raises a violation pulse.

Top module: `twb_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all pulse outputs and `busy` are low.
- R2: Both lines pass two synchronizer flops. An SDA high-to-low change with SCL high, while no transfer is open, gives exactly one `start_pulse` of one cycle.
- R3: The same change while a transfer is open gives one `rstart_pulse` and no `start_pulse`. `busy` stays high.
- R4: An SDA low-to-high change with SCL high gives exactly one `stop_pulse` and closes the open transfer.
- R5: `busy` is high in the cycle of `start_pulse` and stays high while the transfer is open.
- R6: After a stop, `busy` is high for exactly `idle_cycles` system cycles, counting the `stop_pulse` cycle. With `idle_cycles` = 0 it is low in the `stop_pulse` cycle. A start during this window is a start, not a repeated start.
- R7: Bits are counted on SCL falling edges, skipping the first fall after a start or repeated start, modulo 9. A stop with a count other than 0 gives `abort_pulse` in the same cycle as `stop_pulse`. Otherwise no abort is given.
- R8: While a transfer is open, `viol_pulse` fires when the SDA value in the sample where SCL falls differs from the value captured where SCL rose, unless a start or stop occurred in that high phase.
- R9: No `viol_pulse` is produced while no transfer is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level (asynchronous) |
| sda_in | input | 1 | Bus data line level (asynchronous) |
| idle_cycles | input | 16 | Bus-free hold time after a stop, in system clocks |
| start_pulse | output | 1 | Start condition on a free bus |
| rstart_pulse | output | 1 | Start condition on an owned bus |
| stop_pulse | output | 1 | Stop condition |
| viol_pulse | output | 1 | Data changed during a clock-high phase |
| abort_pulse | output | 1 | Stop arrived inside a frame |
| busy | output | 1 | Bus owned or within its free-time hold |

## Verification
The violation pulse is the hardest event to reach from the ports. Any SDA change seen while SCL is high is, by definition, a start or a stop, so a slow data change can never look like a violation. The bench reaches it by changing SDA and dropping SCL in the same system-clock step. Both changes then land in the same synchronized sample, and the falling sample carries the new data level. The bench also runs a repeated start inside a high phase to show that a framing condition there masks the check.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int FRAME_LEN = 9;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int IDLE_W    = 16;
  localparam int SYNC_LEN  = 2;

  typedef logic [CNT_W-1:0]  bitcnt_t;
  typedef logic [IDLE_W-1:0] idle_t;

  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
    logic viol;
    logic abort;
  } cond_evt_t;

  function automatic bitcnt_t bit_step(bitcnt_t c);
    if (c == bitcnt_t'(FRAME_LEN - 1)) return '0;
    return c + bitcnt_t'(1);
  endfunction

  function automatic logic idle_last(idle_t c, idle_t limit);
    return (c + idle_t'(1)) >= limit;
  endfunction
endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
  parameter int W     = 2,
  parameter int DEPTH = twb_pkg::SYNC_LEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic [DEPTH-1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= '1;
      else        stage <= {stage[DEPTH-2:0], d[i]};
    end
    assign q[i] = stage[DEPTH-1];
  end
endmodule

// File: rtl/twb_edges.sv
module twb_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = !scl_q && scl_s;
  assign scl_fall = scl_q && !scl_s;
  assign start_ev = scl_q && scl_s && sda_q && !sda_s;
  assign stop_ev  = scl_q && scl_s && !sda_q && sda_s;
endmodule

// File: rtl/twb_frame.sv
module twb_frame
  import twb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sda_s,
  input  logic      scl_rise,
  input  logic      scl_fall,
  input  logic      start_ev,
  input  logic      stop_ev,
  output logic      owned,
  output cond_evt_t evt
);
  bitcnt_t bcnt;
  logic    armed;
  logic    sda_at_rise;
  logic    cond_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned       <= 1'b0;
      bcnt        <= '0;
      armed       <= 1'b0;
      sda_at_rise <= 1'b1;
      cond_seen   <= 1'b0;
      evt         <= '0;
    end else begin
      evt <= '0;
      if (start_ev) begin
        evt.start  <= !owned;
        evt.rstart <= owned;
        owned      <= 1'b1;
        bcnt       <= '0;
        armed      <= 1'b0;
        cond_seen  <= 1'b1;
      end else if (stop_ev) begin
        evt.stop   <= 1'b1;
        evt.abort  <= owned && (bcnt != '0);
        owned      <= 1'b0;
        bcnt       <= '0;
        armed      <= 1'b0;
        cond_seen  <= 1'b1;
      end else begin
        if (scl_rise) begin
          sda_at_rise <= sda_s;
          cond_seen   <= 1'b0;
        end
        if (scl_fall && owned) begin
          evt.viol <= !cond_seen && (sda_s != sda_at_rise);
          if (!armed) armed <= 1'b1;
          else        bcnt  <= bit_step(bcnt);
        end
      end
    end
  end
endmodule

// File: rtl/twb_idle.sv
module twb_idle
  import twb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_ev,
  input  logic  stop_ev,
  input  logic  owned,
  input  idle_t idle_cycles,
  output logic  busy
);
  idle_t cnt;
  logic  counting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      counting <= 1'b0;
    end else if (stop_ev) begin
      cnt      <= '0;
      counting <= (idle_cycles != '0);
    end else if (start_ev) begin
      counting <= 1'b0;
    end else if (counting) begin
      if (idle_last(cnt, idle_cycles)) counting <= 1'b0;
      else                              cnt      <= cnt + idle_t'(1);
    end
  end

  assign busy = owned || counting;
endmodule

// File: rtl/twb_monitor.sv
module twb_monitor
  import twb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [IDLE_W-1:0] idle_cycles,
  output logic              start_pulse,
  output logic              rstart_pulse,
  output logic              stop_pulse,
  output logic              viol_pulse,
  output logic              abort_pulse,
  output logic              busy
);
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_ev, stop_ev;
  logic       owned;
  cond_evt_t  evt;

  twb_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  twb_edges u_edges (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  twb_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .owned(owned), .evt(evt)
  );

  twb_idle u_idle (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
    .owned(owned), .idle_cycles(idle_cycles), .busy(busy)
  );

  assign start_pulse  = evt.start;
  assign rstart_pulse = evt.rstart;
  assign stop_pulse   = evt.stop;
  assign viol_pulse   = evt.viol;
  assign abort_pulse  = evt.abort;
endmodule

// File: rtl/twb_monitor_chk.sv
module twb_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] idle_cycles,
  input logic        start_pulse,
  input logic        rstart_pulse,
  input logic        stop_pulse,
  input logic        viol_pulse,
  input logic        abort_pulse,
  input logic        busy,
  input logic        start_ev,
  input logic        stop_ev,
  input logic        owned
);
  assert_one_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, rstart_pulse, stop_pulse}));

  assert_start_reported_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (start_pulse || rstart_pulse));

  assert_rstart_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_pulse |-> $past(owned));

  assert_stop_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !owned);

  assert_busy_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse || rstart_pulse) |-> busy);

  assert_zero_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && idle_cycles == 16'd0) |-> !busy);

  assert_abort_with_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> stop_pulse);

  assert_viol_when_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> busy);
endmodule

bind twb_monitor twb_monitor_chk chk_i (.*);

// File: tb/twb_monitor_test.sv
module twb_monitor_test;
  localparam int PERIOD = 10;
  localparam int H      = 8;

  typedef struct packed {
    logic [4:0] nbits;
    logic       rs;
    logic [7:0] pat;
    logic       ex_abort;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{5'd9,  1'b0, 8'hA5, 1'b0},
    '{5'd18, 1'b0, 8'h3C, 1'b0},
    '{5'd3,  1'b0, 8'hF0, 1'b1},
    '{5'd8,  1'b0, 8'h81, 1'b1},
    '{5'd0,  1'b0, 8'h00, 1'b0},
    '{5'd5,  1'b1, 8'h5A, 1'b0},
    '{5'd1,  1'b0, 8'hFF, 1'b1},
    '{5'd10, 1'b0, 8'h69, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1, sda = 1'b1;
  logic [15:0] idle = 16'd4;
  logic        start_pulse, rstart_pulse, stop_pulse, viol_pulse, abort_pulse, busy;

  int n_chk = 0, n_err = 0;
  int c_start = 0, c_rstart = 0, c_stop = 0, c_viol = 0, c_abort = 0;
  int tail = 0;
  logic tail_on = 1'b0;
  logic done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  twb_monitor uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .idle_cycles(idle),
    .start_pulse(start_pulse), .rstart_pulse(rstart_pulse), .stop_pulse(stop_pulse),
    .viol_pulse(viol_pulse), .abort_pulse(abort_pulse), .busy(busy)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      c_start  <= c_start  + int'(start_pulse);
      c_rstart <= c_rstart + int'(rstart_pulse);
      c_stop   <= c_stop   + int'(stop_pulse);
      c_viol   <= c_viol   + int'(viol_pulse);
      c_abort  <= c_abort  + int'(abort_pulse);
      if (stop_pulse) begin
        tail    <= int'(busy);
        tail_on <= busy;
      end else if (tail_on) begin
        if (busy) tail <= tail + 1;
        else      tail_on <= 1'b0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_start();
    scl = 1'b1; sda = 1'b1; wt(H);
    sda = 1'b0; wt(H);
    scl = 1'b0; wt(H);
  endtask

  task automatic do_rstart();
    sda = 1'b1; wt(H);
    scl = 1'b1; wt(H);
    sda = 1'b0; wt(H);
    scl = 1'b0; wt(H);
  endtask

  task automatic do_stop();
    sda = 1'b0; wt(H);
    scl = 1'b1; wt(H);
    sda = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    sda = b; wt(H);
    scl = 1'b1; wt(H);
    scl = 1'b0; wt(H);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int s0, r0, p0, v0, a0;
    wt(3);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 pulses in reset", int'({start_pulse, rstart_pulse, stop_pulse, viol_pulse, abort_pulse}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 pulses after reset", int'({start_pulse, rstart_pulse, stop_pulse, viol_pulse, abort_pulse}), 0);
    wt(H);

    for (int k = 0; k < 8; k++) begin
      s0 = c_start; r0 = c_rstart; p0 = c_stop; v0 = c_viol; a0 = c_abort;
      do_start();
      chk("R5 busy during transfer", int'(busy), 1);
      for (int i = 0; i < int'(TBL[k].nbits); i++) send_bit(TBL[k].pat[7 - (i % 8)]);
      if (TBL[k].rs) begin
        do_rstart();
        chk("R3 busy after repeated start", int'(busy), 1);
        for (int i = 0; i < 9; i++) send_bit(TBL[k].pat[i % 8]);
      end
      do_stop();
      wt(12);
      chk("R2 start count", c_start - s0, 1);
      chk("R3 rstart count", c_rstart - r0, int'(TBL[k].rs));
      chk("R4 stop count", c_stop - p0, 1);
      chk("R7 abort count", c_abort - a0, int'(TBL[k].ex_abort));
      chk("R8 no viol on clean frames", c_viol - v0, 0);
      chk("R6 busy released", int'(busy), 0);
    end

    idle = 16'd20;
    do_start(); send_bit(1'b1); send_bit(1'b0); do_stop();
    wt(40);
    chk("R6 idle tail of 20", tail, 20);

    idle = 16'd0;
    do_start(); do_stop();
    wt(10);
    chk("R6 idle tail of 0", tail, 0);

    idle = 16'd40;
    do_start(); do_stop();
    wt(5);
    chk("R6 still busy in window", int'(busy), 1);
    s0 = c_start; r0 = c_rstart;
    do_start();
    chk("R6 start in window counts as start", c_start - s0, 1);
    chk("R6 start in window not rstart", c_rstart - r0, 0);
    do_stop();
    wt(60);

    idle = 16'd4;
    v0 = c_viol;
    do_start();
    send_bit(1'b1);
    sda = 1'b1; wt(H);
    scl = 1'b1; wt(H);
    scl = 1'b0; sda = 1'b0; wt(H);
    chk("R8 viol on data change at clock fall", c_viol - v0, 1);
    do_stop();
    wt(12);

    v0 = c_viol; s0 = c_start;
    scl = 1'b1; sda = 1'b1; wt(H);
    scl = 1'b0; sda = 1'b0; wt(H);
    sda = 1'b1; wt(H);
    scl = 1'b1; wt(H);
    chk("R9 no viol on free bus", c_viol - v0, 0);
    chk("R9 no start from clocked change", c_start - s0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule